// File: doc/BRIEF.md
# Per-Processor Interrupt Presenter

This block sits between a set of interrupt source controllers and one processor. It holds the interrupt word the processor reads: an 8-bit current processor priority in bits 31:24 and a 24-bit pending source number in bits 23:0, where zero means nothing is pending. Beside that word it keeps the priority of the pending interrupt and a priority register for inter-processor interrupts (IPIs). Lower numbers are more favoured. Source controllers offer interrupts. Each offer carries a source number, a priority and the sender's controller ID. The presenter either takes the offer and raises the processor line, or bounces it straight back.

The presenter also remembers which controller owns the interrupt that is currently pending. When that interrupt is displaced or withdrawn, the bounce goes only to that owner. An IPI has no owner, so displacing it sends no bounce. When the processor signals end-of-interrupt, a notice goes to the controller whose number range holds the source number. If nothing is pending after that, every controller is asked to send its held interrupts again.

Top module: `intr_presenter`

## Requirements
- R1: After reset the processor priority is 0x00, the pending source is 0, the pending priority is 0xFF and the IPI priority is 0xFF. The line is low and no notification is active.
- R2: An offer whose priority is greater than or equal to the processor priority is bounced, and so is one whose priority is not below an existing pending priority. The bounce carries the offer's source and controller ID, one cycle later on the delivery bounce port, and the interrupt word does not change.
- R3: An offer that is taken loads its source, priority and owner and raises the line. If the interrupt it displaces has an owner, that interrupt is bounced to its owner on the delivery bounce port. At all times the line is high exactly when the pending source is non-zero.
- R4: Accept (op code 0) returns the word as it stood before the edge. After the edge the processor priority equals the old pending priority, the pending source is 0, the pending priority is 0xFF and the line is low.
- R5: An IPI-priority write (op code 3, value in data bits 7:0) always stores the value. If the value is below the processor priority, an IPI check runs. The check does nothing when a pending interrupt has priority less than or equal to the value. Otherwise the pending source becomes 2 and the pending priority becomes the value. A displaced owned interrupt is bounced on the op bounce port.
- R6: An IPI has no owner. Displacing or clearing it makes no bounce on either port.
- R7: A priority write (op code 2, value in data bits 31:24) stores the value. If something is pending and the value is less than or equal to the pending priority, the pending interrupt is cleared and the line drops. An owned interrupt cleared this way is bounced on the op bounce port.
- R8: EOI (op code 1) copies data bits 31:24 into the processor priority. Controller k owns sources from 16 + 256k to 16 + 256k + 255, for k from 0 to 3. If data bits 23:0 fall in one of those ranges, an EOI notice goes to that controller one cycle later. Otherwise no notice is sent.
- R9: If no source is pending after an EOI, the resend pulse fires one cycle later. In the same cycle the IPI is reloaded when the IPI priority is below the new processor priority.
- R10: When an op and an offer arrive in the same cycle, the op is applied first. The offer is then judged against the state the op leaves behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Processor operation strobe |
| op_code | input | 2 | 0 accept, 1 EOI, 2 priority write, 3 IPI-priority write |
| op_data | input | 32 | Operation value |
| dlv_valid | input | 1 | Source offer strobe |
| dlv_src | input | 24 | Offered source number |
| dlv_prio | input | 8 | Offered priority |
| dlv_ctrl | input | 2 | Sending controller ID |
| irq_o | output | 1 | Processor interrupt line |
| xirr_o | output | 32 | Interrupt word (priority, pending source) |
| ppri_o | output | 8 | Pending priority |
| mfrr_o | output | 8 | IPI priority |
| oprej_valid | output | 1 | Bounce caused by an operation |
| oprej_src | output | 24 | Bounced source |
| oprej_ctrl | output | 2 | Owner receiving the bounce |
| dlvrej_valid | output | 1 | Bounce caused by an offer |
| dlvrej_src | output | 24 | Bounced source |
| dlvrej_ctrl | output | 2 | Controller receiving the bounce |
| eoi_valid | output | 1 | EOI notice |
| eoi_src | output | 24 | EOI source number |
| eoi_ctrl | output | 2 | Controller owning that source |
| resend_o | output | 1 | Resend request to all controllers |

## Verification
A wrong owner record only shows up the next time the pending interrupt is displaced or withdrawn. At that point a bounce either goes to the wrong controller, or is missing, or is made up for an IPI. That can be many cycles after the fault, so the bench pushes many offers over pending interrupts and checks every bounce port on every cycle. A wrong pending priority shows up one cycle after an accept, as a wrong processor priority, and also as the wrong choice on the next competing offer. Range-decode faults show up in the same cycle the EOI notice appears.

// File: rtl/intr_presenter_pkg.sv
package intr_presenter_pkg;
    localparam int PRIO_W = 8;
    localparam int SRC_W  = 24;
    localparam int WORD_W = PRIO_W + SRC_W;

    localparam logic [PRIO_W-1:0] PRIO_IDLE = '1;
    localparam logic [SRC_W-1:0]  SRC_EMPTY = '0;
    localparam logic [SRC_W-1:0]  IPI_SRC   = SRC_W'(2);

    typedef enum logic [1:0] {
        OP_ACCEPT   = 2'd0,
        OP_EOI      = 2'd1,
        OP_SET_CPPR = 2'd2,
        OP_SET_MFRR = 2'd3
    } proc_op_e;

    typedef struct packed {
        logic [PRIO_W-1:0] cppr;
        logic [SRC_W-1:0]  xisr;
    } pres_word_t;

    // true when priority a is strictly more favoured than b
    function automatic logic more_favoured(input logic [PRIO_W-1:0] a,
                                           input logic [PRIO_W-1:0] b);
        return a < b;
    endfunction
endpackage

// File: rtl/intr_presenter_range.sv
module intr_presenter_range
    import intr_presenter_pkg::*;
#(
    parameter int N_CTRL     = 4,
    parameter int RANGE_BASE = 16,
    parameter int RANGE_LG   = 8,
    parameter int ID_W       = 2
) (
    input  logic [SRC_W-1:0] src,
    output logic             hit,
    output logic [ID_W-1:0]  id
);
    localparam logic [31:0] SPAN = 32'(1) << RANGE_LG;

    logic [N_CTRL-1:0] in_rng;

    for (genvar k = 0; k < N_CTRL; k++) begin : g_rng
        localparam logic [31:0] LO = 32'(RANGE_BASE) + 32'(k) * SPAN;
        assign in_rng[k] = (32'(src) >= LO) && (32'(src) < LO + SPAN);
    end

    always_comb begin
        id = '0;
        for (int i = 0; i < N_CTRL; i++) begin
            if (in_rng[i]) id = id | ID_W'(i);
        end
    end

    assign hit = |in_rng;
endmodule

// File: rtl/intr_presenter_note.sv
module intr_presenter_note #(
    parameter int DW = 26
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          d_valid,
    input  logic [DW-1:0] d_data,
    output logic          q_valid,
    output logic [DW-1:0] q_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
            q_data  <= '0;
        end else begin
            q_valid <= d_valid;
            q_data  <= d_valid ? d_data : '0;
        end
    end
endmodule

// File: rtl/intr_presenter_state.sv
module intr_presenter_state
    import intr_presenter_pkg::*;
#(
    parameter int ID_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [1:0]        op_code,
    input  logic [WORD_W-1:0] op_data,
    input  logic              dlv_valid,
    input  logic [SRC_W-1:0]  dlv_src,
    input  logic [PRIO_W-1:0] dlv_prio,
    input  logic [ID_W-1:0]   dlv_ctrl,
    input  logic              eoi_hit,
    input  logic [ID_W-1:0]   eoi_id,
    output pres_word_t        word_q,
    output logic [PRIO_W-1:0] ppri_q,
    output logic [PRIO_W-1:0] mfrr_q,
    output logic              irq_q,
    output logic              orj_v,
    output logic [SRC_W-1:0]  orj_src,
    output logic [ID_W-1:0]   orj_id,
    output logic              drj_v,
    output logic [SRC_W-1:0]  drj_src,
    output logic [ID_W-1:0]   drj_id,
    output logic              eoi_v,
    output logic [SRC_W-1:0]  eoi_src,
    output logic [ID_W-1:0]   eoi_id_o,
    output logic              resend
);
    proc_op_e          op;
    pres_word_t        w_n;
    logic [PRIO_W-1:0] pp_n, mf_n;
    logic [ID_W-1:0]   own_q, own_n;
    logic              ownv_q, ownv_n, irq_n;

    assign op = proc_op_e'(op_code);

    always_comb begin
        w_n = word_q;  pp_n = ppri_q;  mf_n = mfrr_q;
        own_n = own_q; ownv_n = ownv_q; irq_n = irq_q;
        orj_v = 1'b0; orj_src = '0; orj_id = '0;
        drj_v = 1'b0; drj_src = '0; drj_id = '0;
        eoi_v = 1'b0; eoi_src = '0; eoi_id_o = '0;
        resend = 1'b0;

        if (op_valid) begin
            unique case (op)
                OP_ACCEPT: begin
                    w_n.cppr = pp_n;
                    w_n.xisr = SRC_EMPTY;
                    pp_n     = PRIO_IDLE;
                    ownv_n   = 1'b0;
                    irq_n    = 1'b0;
                end
                OP_SET_CPPR: begin
                    w_n.cppr = op_data[31:24];
                    if (w_n.xisr != SRC_EMPTY && w_n.cppr <= pp_n) begin
                        if (ownv_n) begin
                            orj_v = 1'b1; orj_src = w_n.xisr; orj_id = own_n;
                        end
                        w_n.xisr = SRC_EMPTY;
                        pp_n     = PRIO_IDLE;
                        ownv_n   = 1'b0;
                        irq_n    = 1'b0;
                    end
                end
                OP_SET_MFRR: begin
                    mf_n = op_data[7:0];
                    if (more_favoured(mf_n, w_n.cppr) &&
                        !(w_n.xisr != SRC_EMPTY && pp_n <= mf_n)) begin
                        if (w_n.xisr != SRC_EMPTY && ownv_n) begin
                            orj_v = 1'b1; orj_src = w_n.xisr; orj_id = own_n;
                        end
                        w_n.xisr = IPI_SRC;
                        pp_n     = mf_n;
                        ownv_n   = 1'b0;
                        irq_n    = 1'b1;
                    end
                end
                OP_EOI: begin
                    w_n.cppr = op_data[31:24];
                    eoi_v    = eoi_hit;
                    eoi_src  = eoi_hit ? op_data[23:0] : '0;
                    eoi_id_o = eoi_hit ? eoi_id : '0;
                    if (w_n.xisr == SRC_EMPTY) begin
                        resend = 1'b1;
                        if (more_favoured(mf_n, w_n.cppr)) begin
                            w_n.xisr = IPI_SRC;
                            pp_n     = mf_n;
                            ownv_n   = 1'b0;
                            irq_n    = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end

        if (dlv_valid) begin
            if (!more_favoured(dlv_prio, w_n.cppr) ||
                (w_n.xisr != SRC_EMPTY && pp_n <= dlv_prio)) begin
                drj_v = 1'b1; drj_src = dlv_src; drj_id = dlv_ctrl;
            end else begin
                if (w_n.xisr != SRC_EMPTY && ownv_n) begin
                    drj_v = 1'b1; drj_src = w_n.xisr; drj_id = own_n;
                end
                w_n.xisr = dlv_src;
                pp_n     = dlv_prio;
                own_n    = dlv_ctrl;
                ownv_n   = 1'b1;
                irq_n    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '{cppr: '0, xisr: SRC_EMPTY};
            ppri_q <= PRIO_IDLE;
            mfrr_q <= PRIO_IDLE;
            own_q  <= '0;
            ownv_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            word_q <= w_n;
            ppri_q <= pp_n;
            mfrr_q <= mf_n;
            own_q  <= own_n;
            ownv_q <= ownv_n;
            irq_q  <= irq_n;
        end
    end
endmodule

// File: rtl/intr_presenter.sv
module intr_presenter
    import intr_presenter_pkg::*;
#(
    parameter int N_CTRL     = 4,
    parameter int RANGE_BASE = 16,
    parameter int RANGE_LG   = 8,
    parameter int ID_W       = (N_CTRL > 1) ? $clog2(N_CTRL) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [1:0]        op_code,
    input  logic [31:0]       op_data,
    input  logic              dlv_valid,
    input  logic [23:0]       dlv_src,
    input  logic [7:0]        dlv_prio,
    input  logic [ID_W-1:0]   dlv_ctrl,
    output logic              irq_o,
    output logic [31:0]       xirr_o,
    output logic [7:0]        ppri_o,
    output logic [7:0]        mfrr_o,
    output logic              oprej_valid,
    output logic [23:0]       oprej_src,
    output logic [ID_W-1:0]   oprej_ctrl,
    output logic              dlvrej_valid,
    output logic [23:0]       dlvrej_src,
    output logic [ID_W-1:0]   dlvrej_ctrl,
    output logic              eoi_valid,
    output logic [23:0]       eoi_src,
    output logic [ID_W-1:0]   eoi_ctrl,
    output logic              resend_o
);
    localparam int NOTE_W = SRC_W + ID_W;

    pres_word_t        word;
    logic              hit;
    logic [ID_W-1:0]   hit_id;
    logic              orj_v, drj_v, eoi_v, resend_d;
    logic [SRC_W-1:0]  orj_src, drj_src, eoi_s;
    logic [ID_W-1:0]   orj_id, drj_id, eoi_i;

    intr_presenter_range #(
        .N_CTRL(N_CTRL), .RANGE_BASE(RANGE_BASE),
        .RANGE_LG(RANGE_LG), .ID_W(ID_W)
    ) u_range (
        .src(op_data[23:0]), .hit(hit), .id(hit_id)
    );

    intr_presenter_state #(.ID_W(ID_W)) u_state (
        .clk(clk), .rst(rst),
        .op_valid(op_valid), .op_code(op_code), .op_data(op_data),
        .dlv_valid(dlv_valid), .dlv_src(dlv_src), .dlv_prio(dlv_prio),
        .dlv_ctrl(dlv_ctrl), .eoi_hit(hit), .eoi_id(hit_id),
        .word_q(word), .ppri_q(ppri_o), .mfrr_q(mfrr_o), .irq_q(irq_o),
        .orj_v(orj_v), .orj_src(orj_src), .orj_id(orj_id),
        .drj_v(drj_v), .drj_src(drj_src), .drj_id(drj_id),
        .eoi_v(eoi_v), .eoi_src(eoi_s), .eoi_id_o(eoi_i),
        .resend(resend_d)
    );

    intr_presenter_note #(.DW(NOTE_W)) u_note_op (
        .clk(clk), .rst(rst), .d_valid(orj_v), .d_data({orj_src, orj_id}),
        .q_valid(oprej_valid), .q_data({oprej_src, oprej_ctrl})
    );

    intr_presenter_note #(.DW(NOTE_W)) u_note_dlv (
        .clk(clk), .rst(rst), .d_valid(drj_v), .d_data({drj_src, drj_id}),
        .q_valid(dlvrej_valid), .q_data({dlvrej_src, dlvrej_ctrl})
    );

    intr_presenter_note #(.DW(NOTE_W)) u_note_eoi (
        .clk(clk), .rst(rst), .d_valid(eoi_v), .d_data({eoi_s, eoi_i}),
        .q_valid(eoi_valid), .q_data({eoi_src, eoi_ctrl})
    );

    always_ff @(posedge clk) begin
        if (rst) resend_o <= 1'b0;
        else     resend_o <= resend_d;
    end

    assign xirr_o = word;
endmodule

// File: rtl/intr_presenter_chk.sv
module intr_presenter_chk #(
    parameter int RANGE_BASE = 16,
    parameter int RANGE_LG   = 8,
    parameter int ID_W       = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            op_valid,
    input logic [1:0]      op_code,
    input logic [31:0]     op_data,
    input logic            dlv_valid,
    input logic [23:0]     dlv_src,
    input logic [7:0]      dlv_prio,
    input logic [ID_W-1:0] dlv_ctrl,
    input logic            irq_o,
    input logic [31:0]     xirr_o,
    input logic [7:0]      ppri_o,
    input logic [7:0]      mfrr_o,
    input logic            dlvrej_valid,
    input logic [23:0]     dlvrej_src,
    input logic [ID_W-1:0] dlvrej_ctrl,
    input logic            eoi_valid,
    input logic [23:0]     eoi_src,
    input logic [ID_W-1:0] eoi_ctrl
);
    assert_line_tracks_R3: assert property (@(posedge clk) disable iff (rst)
        irq_o == (xirr_o[23:0] != 24'd0));

    assert_idle_prio_R4: assert property (@(posedge clk) disable iff (rst)
        (xirr_o[23:0] == 24'd0) |-> (ppri_o == 8'hFF));

    assert_accept_R4: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 2'd0 && !dlv_valid) |=>
        (xirr_o[23:0] == 24'd0 && !irq_o &&
         xirr_o[31:24] == $past(ppri_o) && ppri_o == 8'hFF));

    assert_bounce_low_R2: assert property (@(posedge clk) disable iff (rst)
        (dlv_valid && !op_valid && dlv_prio >= xirr_o[31:24]) |=>
        (dlvrej_valid && dlvrej_src == $past(dlv_src) &&
         dlvrej_ctrl == $past(dlv_ctrl) && $stable(xirr_o)));

    assert_mfrr_store_R5: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 2'd3) |=> (mfrr_o == $past(op_data[7:0])));

    assert_eoi_cppr_R8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 2'd1) |=> (xirr_o[31:24] == $past(op_data[31:24])));

    assert_eoi_range_R8: assert property (@(posedge clk) disable iff (rst)
        eoi_valid |->
        ((32'(eoi_src) >= 32'(RANGE_BASE) + (32'(eoi_ctrl) << RANGE_LG)) &&
         (32'(eoi_src) <  32'(RANGE_BASE) + ((32'(eoi_ctrl) + 32'd1) << RANGE_LG))));
endmodule

bind intr_presenter intr_presenter_chk #(
    .RANGE_BASE(RANGE_BASE), .RANGE_LG(RANGE_LG), .ID_W(ID_W)
) u_chk (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .op_data(op_data), .dlv_valid(dlv_valid), .dlv_src(dlv_src),
    .dlv_prio(dlv_prio), .dlv_ctrl(dlv_ctrl), .irq_o(irq_o),
    .xirr_o(xirr_o), .ppri_o(ppri_o), .mfrr_o(mfrr_o),
    .dlvrej_valid(dlvrej_valid), .dlvrej_src(dlvrej_src),
    .dlvrej_ctrl(dlvrej_ctrl), .eoi_valid(eoi_valid),
    .eoi_src(eoi_src), .eoi_ctrl(eoi_ctrl)
);

// File: tb/intr_presenter_test.sv
module intr_presenter_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [1:0]  op_code = 2'd0;
    logic [31:0] op_data = 32'd0;
    logic        dlv_valid = 1'b0;
    logic [23:0] dlv_src = 24'd0;
    logic [7:0]  dlv_prio = 8'd0;
    logic [1:0]  dlv_ctrl = 2'd0;
    logic        irq_o, oprej_valid, dlvrej_valid, eoi_valid, resend_o;
    logic [31:0] xirr_o;
    logic [7:0]  ppri_o, mfrr_o;
    logic [23:0] oprej_src, dlvrej_src, eoi_src;
    logic [1:0]  oprej_ctrl, dlvrej_ctrl, eoi_ctrl;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    intr_presenter uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .op_data(op_data), .dlv_valid(dlv_valid), .dlv_src(dlv_src),
        .dlv_prio(dlv_prio), .dlv_ctrl(dlv_ctrl), .irq_o(irq_o),
        .xirr_o(xirr_o), .ppri_o(ppri_o), .mfrr_o(mfrr_o),
        .oprej_valid(oprej_valid), .oprej_src(oprej_src), .oprej_ctrl(oprej_ctrl),
        .dlvrej_valid(dlvrej_valid), .dlvrej_src(dlvrej_src),
        .dlvrej_ctrl(dlvrej_ctrl), .eoi_valid(eoi_valid), .eoi_src(eoi_src),
        .eoi_ctrl(eoi_ctrl), .resend_o(resend_o)
    );

    // reference state
    logic [7:0]  m_c, m_pp, m_mf;
    logic [23:0] m_x;
    logic [1:0]  m_own;
    logic        m_ownv;
    logic        e_orv, e_drv, e_ev, e_rs;
    logic [23:0] e_ors, e_drs, e_es;
    logic [1:0]  e_orc, e_drc, e_ec;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic in_ranges(input logic [23:0] s);
        return (s >= 24'd16) && (s < 24'd16 + 24'd1024);
    endfunction

    function automatic logic [1:0] range_id(input logic [23:0] s);
        logic [23:0] off;
        off = s - 24'd16;
        return off[9:8];
    endfunction

    task automatic model_reset();
        m_c = 8'h00; m_x = 24'd0; m_pp = 8'hFF; m_mf = 8'hFF;
        m_own = 2'd0; m_ownv = 1'b0;
    endtask

    task automatic model(input bit ov, input logic [1:0] oc, input logic [31:0] od,
                         input bit dv, input logic [23:0] ds, input logic [7:0] dp,
                         input logic [1:0] dc);
        e_orv = 0; e_drv = 0; e_ev = 0; e_rs = 0;
        e_ors = 0; e_drs = 0; e_es = 0; e_orc = 0; e_drc = 0; e_ec = 0;
        if (ov) begin
            if (oc == 2'd0) begin
                m_c = m_pp; m_x = 0; m_pp = 8'hFF; m_ownv = 0;
            end else if (oc == 2'd2) begin
                m_c = od[31:24];
                if (m_x != 0 && m_c <= m_pp) begin
                    if (m_ownv) begin e_orv = 1; e_ors = m_x; e_orc = m_own; end
                    m_x = 0; m_pp = 8'hFF; m_ownv = 0;
                end
            end else if (oc == 2'd3) begin
                m_mf = od[7:0];
                if (m_mf < m_c && !(m_x != 0 && m_pp <= m_mf)) begin
                    if (m_x != 0 && m_ownv) begin e_orv = 1; e_ors = m_x; e_orc = m_own; end
                    m_x = 24'd2; m_pp = m_mf; m_ownv = 0;
                end
            end else begin
                m_c = od[31:24];
                if (in_ranges(od[23:0])) begin
                    e_ev = 1; e_es = od[23:0]; e_ec = range_id(od[23:0]);
                end
                if (m_x == 0) begin
                    e_rs = 1;
                    if (m_mf < m_c) begin m_x = 24'd2; m_pp = m_mf; m_ownv = 0; end
                end
            end
        end
        if (dv) begin
            if (dp >= m_c || (m_x != 0 && m_pp <= dp)) begin
                e_drv = 1; e_drs = ds; e_drc = dc;
            end else begin
                if (m_x != 0 && m_ownv) begin e_drv = 1; e_drs = m_x; e_drc = m_own; end
                m_x = ds; m_pp = dp; m_own = dc; m_ownv = 1;
            end
        end
    endtask

    task automatic compare(input string tag);
        chk(tag, "xirr", xirr_o, {m_c, m_x});
        chk(tag, "ppri", {24'd0, ppri_o}, {24'd0, m_pp});
        chk(tag, "mfrr", {24'd0, mfrr_o}, {24'd0, m_mf});
        chk(tag, "irq", {31'd0, irq_o}, {31'd0, (m_x != 0)});
        chk(tag, "oprej_valid", {31'd0, oprej_valid}, {31'd0, e_orv});
        if (e_orv) chk(tag, "oprej", {6'd0, oprej_ctrl, oprej_src}, {6'd0, e_orc, e_ors});
        chk(tag, "dlvrej_valid", {31'd0, dlvrej_valid}, {31'd0, e_drv});
        if (e_drv) chk(tag, "dlvrej", {6'd0, dlvrej_ctrl, dlvrej_src}, {6'd0, e_drc, e_drs});
        chk(tag, "eoi_valid", {31'd0, eoi_valid}, {31'd0, e_ev});
        if (e_ev) chk(tag, "eoi", {6'd0, eoi_ctrl, eoi_src}, {6'd0, e_ec, e_es});
        chk(tag, "resend", {31'd0, resend_o}, {31'd0, e_rs});
    endtask

    task automatic step(input string tag, input bit ov, input logic [1:0] oc,
                        input logic [31:0] od, input bit dv, input logic [23:0] ds,
                        input logic [7:0] dp, input logic [1:0] dc);
        op_valid = ov; op_code = oc; op_data = od;
        dlv_valid = dv; dlv_src = ds; dlv_prio = dp; dlv_ctrl = dc;
        #1;
        if (ov && oc == 2'd0) chk(tag, "accept read", xirr_o, {m_c, m_x});
        model(ov, oc, od, dv, ds, dp, dc);
        @(posedge clk); #2;
        compare(tag);
        @(negedge clk);
        op_valid = 0; dlv_valid = 0;
    endtask

    function automatic logic [7:0] pick_prio();
        int r;
        r = $urandom_range(0, 9);
        return (r > 7) ? 8'hFF : 8'(r);
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        e_orv = 0; e_drv = 0; e_ev = 0; e_rs = 0;
        e_ors = 0; e_drs = 0; e_es = 0; e_orc = 0; e_drc = 0; e_ec = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1 compare("R1");

        step("R2", 0, 0, 0, 1, 24'd40, 8'd3, 2'd0);              // cppr 0 blocks all
        step("R7", 1, 2, 32'hFF00_0000, 0, 0, 0, 0);             // open priority
        step("R3", 0, 0, 0, 1, 24'd20, 8'd5, 2'd0);
        step("R3", 0, 0, 0, 1, 24'd300, 8'd3, 2'd1);             // displaces owned 20
        step("R2", 0, 0, 0, 1, 24'd600, 8'd4, 2'd2);             // not better than pending
        step("R4", 1, 0, 0, 0, 0, 0, 0);
        step("R8", 1, 1, {8'hFF, 24'd300}, 0, 0, 0, 0);          // R9 resend too
        step("R5", 1, 3, 32'd6, 0, 0, 0, 0);                     // IPI loaded
        step("R6", 0, 0, 0, 1, 24'd20, 8'd2, 2'd0);              // displaces IPI silently
        step("R5", 1, 3, 32'd1, 0, 0, 0, 0);                     // IPI displaces owned 20
        step("R5", 1, 3, 32'd4, 0, 0, 0, 0);                     // pending 1 <= 4: no change
        step("R6", 1, 2, 32'h0100_0000, 0, 0, 0, 0);             // clears IPI, no bounce
        step("R9", 1, 1, {8'hFF, 24'd5}, 0, 0, 0, 0);            // out of range, IPI reload
        step("R8", 1, 1, {8'h80, 24'd1039}, 0, 0, 0, 0);         // top of last range
        step("R4", 1, 0, 0, 0, 0, 0, 0);
        step("R7", 1, 2, 32'hFF00_0000, 1, 24'd700, 8'd9, 2'd3);
        step("R10", 1, 2, 32'h0000_0000, 1, 24'd50, 8'd3, 2'd1); // op first: offer bounced
        step("R10", 1, 2, 32'h0800_0000, 1, 24'd51, 8'd3, 2'd2);

        for (int i = 0; i < 4000; i++) begin
            bit ov, dv;
            logic [1:0] oc;
            logic [31:0] od;
            ov = ($urandom_range(0, 9) < 4);
            dv = ($urandom_range(0, 9) < 6);
            oc = 2'($urandom_range(0, 3));
            case (oc)
                2'd3:    od = {24'd0, pick_prio()};
                2'd1:    od = {pick_prio(), 24'($urandom_range(0, 1100))};
                default: od = {pick_prio(), 24'd0};
            endcase
            step("R10", ov, oc, od, dv, 24'($urandom_range(3, 1100)),
                 pick_prio(), 2'($urandom_range(0, 3)));
        end

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule